// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog

This block is a 16-bit down-counter on a small 32-bit register bus. A power-of-two prescaler sits in front of it. A 2-bit mode field sets what happens when the count runs out:
- The counter can wrap and keep running.
- It can reload and raise an interrupt pulse.
- It can raise the interrupt pulse once and stop.
- It can act as a watchdog that requests a system reset.

In watchdog mode, software keeps the system alive by writing the load register before the count expires. Each such write restarts the count at once.

Expiry in watchdog mode has three effects. It drives a reset-request output for a fixed number of clock cycles. It sets a timer status flag. It also sets a sticky reset-cause flag. Only the power-on reset input or a write-one-to-clear access clears the cause flag, so software can learn after the restart that the watchdog caused it.

A mode or prescale change written while the timer runs is held as pending. It takes effect at the next reload of the counter.

Top module: `tmr_wdg_top`

## Requirements
- R1: After power-on reset (rst_ni low), every readable register reads 0, and irq_o and sys_rst_o are low.
- R2: A write to offset 0x00 stores a 16-bit load value and sets the counter to that value in the same cycle. Reads of offset 0x00 return the current count in bits 15:0.
- R3: Writing the control register (offset 0x08) with bit 7 set while the timer is stopped starts counting from the stored load value. The count drops by one per prescaled tick. A tick that finds the count at 0 is the expiry, so load value L expires after L+1 ticks.
- R4: Control bits 3:0 choose the tick period. Code n (0..14) gives one tick every 2^n clock cycles, and code 15 gives one tick every 65536 cycles. The prescaler restarts on every reload.
- R5: In periodic mode (control bits 5:4 = 1), expiry reloads the load value and drives irq_o high for exactly one cycle.
- R6: In one-shot mode (bits 5:4 = 2), expiry drives irq_o for one cycle, clears control bit 7 and leaves the count at 0.
- R7: In free-running mode (bits 5:4 = 0), expiry sets the count to 0xFFFF and raises no interrupt.
- R8: In watchdog mode (bits 5:4 = 3), expiry has these effects:
  - sys_rst_o goes high for exactly 4 cycles.
  - No interrupt is raised.
  - Control bit 7 clears.
  - Bit 5 of the status register (offset 0x04) is set.
  - Bit 1 of the cause register (offset 0x38) is set.
- R9: A load write while the timer runs reloads the counter at once and restarts the prescaler. In watchdog mode, writes repeated before expiry hold off the reset request indefinitely.
- R10: Mode and prescale values written while the timer runs read back at once from offset 0x08. They take effect only at the next reload.
- R11: Cause bit 1 at offset 0x38 clears only on power-on reset or on a write with bit 1 set. Status bit 5 at offset 0x04 clears when the timer is started again.
- R12: Writing control bit 7 as 0 stops the timer, and the count then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on periodic or one-shot expiry |
| sys_rst_o | output | 1 | System reset request on watchdog expiry |

## Verification
A corrupted count shows up on the next read of offset 0x00. When the timer is running, it also moves the expiry edge by whole ticks, so a table of load/prescale/mode vectors measures the exact expiry cycle. A broken prescaler scales that error by the tick period, so it appears within one period. A stale or prematurely applied pending mode does not show until the next reload. The pending-change test therefore measures two consecutive periods, the first at the old rate and the second at the new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_WDOG     = 2'd3
  } tmr_mode_e;

  localparam int OFF_LOAD  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_CAUSE = 'h38;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_LSB = 4;
  localparam int STAT_FIRE_BIT = 5;
  localparam int CAUSE_WD_BIT  = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int DIV_W = 1 << PS_W;
  localparam int SH_W  = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] div_q;
  logic [SH_W-1:0]  shift;
  logic [DIV_W:0]   mask;

  // top code extends to the full divider width
  always_comb begin
    shift = (sel_i == '1) ? SH_W'(DIV_W) : SH_W'(sel_i);
    mask  = ((DIV_W+1)'(1) << shift) - (DIV_W+1)'(1);
  end

  assign tick_o = run_i && ((div_q & mask[DIV_W-1:0]) == mask[DIV_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (reload_i)                      cnt_q <= reload_val_i;
    else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  assign req_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (fire_i)  left_q <= LW'(LEN);
    else if (req_o)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/tmr_wdg_top.sv
module tmr_wdg_top
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int PS_W    = 4,
  parameter int RST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int MODE_MSB = CTRL_MODE_LSB + 1;

  logic             wr_load, wr_ctrl, wr_cause, start;
  logic             en_q, irq_q, fired_q, cause_q;
  tmr_mode_e        mode_cfg_q, mode_act_q, mode_wr;
  logic [PS_W-1:0]  ps_cfg_q, ps_act_q;
  logic [CNT_W-1:0] load_q, cnt_q, reload_val;
  logic             tick, expire, reload, wdog_fire;

  assign wr_load  = we_i && (addr_i == ADDR_W'(OFF_LOAD));
  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_cause = we_i && (addr_i == ADDR_W'(OFF_CAUSE));
  assign start    = wr_ctrl && wdata_i[CTRL_EN_BIT] && !en_q;
  assign mode_wr  = tmr_mode_e'(wdata_i[MODE_MSB:CTRL_MODE_LSB]);

  assign wdog_fire = expire && (mode_act_q == MODE_WDOG);
  assign reload    = start || wr_load ||
                     (expire && (mode_act_q == MODE_PERIODIC || mode_act_q == MODE_FREE));

  always_comb begin
    if (wr_load)                                reload_val = wdata_i[CNT_W-1:0];
    else if (expire && mode_act_q == MODE_FREE) reload_val = '1;
    else                                        reload_val = load_q;
  end

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .clr_i  (reload),
    .sel_i  (ps_act_q),
    .tick_o (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (en_q),
    .tick_i       (tick),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .cnt_o        (cnt_q),
    .expire_o     (expire)
  );

  tmr_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wdog_fire),
    .req_o  (sys_rst_o)
  );

  // programmed fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      mode_cfg_q <= MODE_FREE;
      ps_cfg_q   <= '0;
      load_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q       <= wdata_i[CTRL_EN_BIT];
        mode_cfg_q <= mode_wr;
        ps_cfg_q   <= wdata_i[PS_W-1:0];
      end else if (expire && (mode_act_q == MODE_ONESHOT || mode_act_q == MODE_WDOG)) begin
        en_q <= 1'b0;
      end
      if (wr_load) load_q <= wdata_i[CNT_W-1:0];
    end
  end

  // active fields, latched at each reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_act_q <= MODE_FREE;
      ps_act_q   <= '0;
    end else if (reload) begin
      mode_act_q <= wr_ctrl ? mode_wr : mode_cfg_q;
      ps_act_q   <= wr_ctrl ? wdata_i[PS_W-1:0] : ps_cfg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      fired_q <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      irq_q <= expire && (mode_act_q == MODE_PERIODIC || mode_act_q == MODE_ONESHOT);
      if (wdog_fire)  fired_q <= 1'b1;
      else if (start) fired_q <= 1'b0;
      if (wdog_fire)  cause_q <= 1'b1;
      else if (wr_cause && wdata_i[CAUSE_WD_BIT]) cause_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_LOAD):  rdata_o[CNT_W-1:0] = cnt_q;
      ADDR_W'(OFF_STAT):  rdata_o[STAT_FIRE_BIT] = fired_q;
      ADDR_W'(OFF_CTRL): begin
        rdata_o[CTRL_EN_BIT]                = en_q;
        rdata_o[MODE_MSB:CTRL_MODE_LSB]     = mode_cfg_q;
        rdata_o[PS_W-1:0]                   = ps_cfg_q;
      end
      ADDR_W'(OFF_CAUSE): rdata_o[CAUSE_WD_BIT] = cause_q;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_wdg_chk.sv
module tmr_wdg_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             en_q,
  input logic             cause_q,
  input logic [CNT_W-1:0] cnt_q,
  input tmr_mode_e        mode_act_q,
  input logic             irq_o,
  input logic             sys_rst_o
);
  // R8
  rst_sets_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> cause_q);

  // R8
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ##1 sys_rst_o ##1 sys_rst_o ##1 sys_rst_o ##1 !sys_rst_o);

  // R12
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !we_i) |=> $stable(cnt_q));

  // R5
  irq_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_q) && ($past(mode_act_q) == MODE_PERIODIC ||
                              $past(mode_act_q) == MODE_ONESHOT));
endmodule

bind tmr_wdg_top tmr_wdg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .en_q       (en_q),
  .cause_q    (cause_q),
  .cnt_q      (cnt_q),
  .mode_act_q (mode_act_q),
  .irq_o      (irq_o),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/tb_tmr_wdg_top.sv
`timescale 1ns/100ps
module tb_tmr_wdg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, sys_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  tmr_wdg_top dut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  ps;
    logic [15:0] load;
    logic [31:0] cyc;
  } vec_t;

  // expiry after (load+1) ticks of 2^ps cycles (code 15 -> 65536)
  localparam vec_t VECS [7] = '{
    '{2'd1, 4'd0,  16'd5,  32'd6},
    '{2'd2, 4'd0,  16'd0,  32'd1},
    '{2'd2, 4'd2,  16'd3,  32'd16},
    '{2'd1, 4'd1,  16'd10, 32'd22},
    '{2'd3, 4'd0,  16'd7,  32'd8},
    '{2'd3, 4'd3,  16'd2,  32'd24},
    '{2'd2, 4'd15, 16'd0,  32'd65536}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0; addr_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5 d = rdata_o;
    addr_i = '0;
  endtask

  // edges until the event output goes high
  task automatic wait_evt(bit use_rst, int lim, output int n, output bit irq_seen);
    n = 0; irq_seen = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk_i); #1;
      if (irq_o) irq_seen = 1;
      if (use_rst ? sys_rst_o : irq_o) begin n = i; break; end
    end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    bit irq_seen;

    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 sys_rst", {31'd0, sys_rst_o}, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd(8'h00, d); chk("R1 load", d, 0);
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h38, d); chk("R1 cause", d, 0);

    // R2
    wr(8'h00, 32'h1234);
    rd(8'h00, d); chk("R2 count readback", d, 32'h1234);

    // table walk: R3 R4 R5 R6 R8
    for (int v = 0; v < 7; v++) begin
      wr(8'h00, {16'd0, VECS[v].load});
      wr(8'h08, {24'd0, 1'b1, 1'b0, VECS[v].mode, VECS[v].ps});
      wait_evt(VECS[v].mode == 2'd3, int'(VECS[v].cyc) + 8, n, irq_seen);
      chk("R3 R4 expiry cycle", n, VECS[v].cyc);
      rd(8'h00, d);
      if (VECS[v].mode == 2'd1) chk("R5 reload on expiry", d, {16'd0, VECS[v].load});
      else                      chk("R6 R8 count at 0", d, 0);
      if (VECS[v].mode == 2'd1) begin
        @(posedge clk_i); #1;
        chk("R5 one-cycle irq", {31'd0, irq_o}, 0);
      end
      if (VECS[v].mode != 2'd1) begin
        rd(8'h08, d); chk("R6 R8 enable cleared", {31'd0, d[7]}, 0);
      end
      if (VECS[v].mode == 2'd3) begin
        chk("R8 no irq", {31'd0, irq_seen}, 0);
        rd(8'h38, d); chk("R8 cause set", d, 32'h2);
        rd(8'h04, d); chk("R8 status set", d, 32'h20);
      end
      wr(8'h08, 32'h0);
      repeat (6) @(posedge clk_i);
      #1;
      wr(8'h38, 32'h2);
    end

    // R12
    wr(8'h00, 32'd100);
    wr(8'h08, 32'h90);
    repeat (9) @(posedge clk_i);
    #1;
    wr(8'h08, 32'h10);
    rd(8'h00, d); chk("R12 count at stop", d, 32'd90);
    repeat (5) @(posedge clk_i);
    #1;
    rd(8'h00, d); chk("R12 count held", d, 32'd90);

    // R7
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h80);
    irq_seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i); #1;
      if (irq_o) irq_seen = 1;
    end
    rd(8'h00, d); chk("R7 wrap to 0xFFFF", d, 32'hFFFF);
    chk("R7 no irq", {31'd0, irq_seen}, 0);
    @(posedge clk_i); #1;
    rd(8'h00, d); chk("R7 keeps counting", d, 32'hFFFE);
    wr(8'h08, 32'h0);

    // R10
    wr(8'h00, 32'd4);
    wr(8'h08, 32'h90);
    wr(8'h08, 32'h91);
    rd(8'h08, d); chk("R10 pending readback", d, 32'h91);
    wait_evt(0, 20, n, irq_seen);
    chk("R10 old rate until reload", n, 4);
    wait_evt(0, 30, n, irq_seen);
    chk("R10 new rate after reload", n, 10);
    wr(8'h08, 32'h0);

    // R9
    wr(8'h00, 32'd20);
    wr(8'h08, 32'hB0);
    for (int k = 0; k < 3; k++) begin
      repeat (15) @(posedge clk_i);
      #1;
      chk("R9 no reset while fed", {31'd0, sys_rst_o}, 0);
      wr(8'h00, 32'd20);
    end
    wait_evt(1, 40, n, irq_seen);
    chk("R9 expiry after last feed", n, 21);
    n = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_i); #1;
      if (sys_rst_o) n++;
    end
    chk("R8 request length", n, 4);

    // R11
    wr(8'h38, 32'h0);
    rd(8'h38, d); chk("R11 cause kept on write 0", d, 32'h2);
    wr(8'h00, 32'd500);
    wr(8'h08, 32'hB0);
    rd(8'h04, d); chk("R11 status cleared on start", d, 0);
    rd(8'h38, d); chk("R11 cause kept on restart", d, 32'h2);
    wr(8'h08, 32'h0);
    wr(8'h38, 32'h2);
    rd(8'h38, d); chk("R11 cause cleared by W1C", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule